// File: doc/BRIEF.md
# Smart Card Clock and Bit-Timing Generator

This block turns a fast master clock into the two time bases a smart card interface needs. A programmable prescaler divides the master clock by a 6-bit ratio. A toggle stage halves the prescaled rate to form the card clock, and a gating input can park that clock low without shortening a high phase.

A 12-bit bit-time counter runs from the prescaled ticks. Its length comes from a packed 8-bit rate register. The high nibble picks a clock-rate conversion factor and the low nibble picks a baud-adjust divisor. The counter emits a one-cycle strobe at every bit boundary and a second one-cycle strobe at the middle of the bit, which a receiver uses to sample. A new rate-register value is held back until the bit in progress has finished. Reserved codes leave the running bit length as it was.

Top module: `scg_clk_etu`

## Requirements
- R1: After reset `card_clk`, `cclk_stb`, `etu_edge` and `etu_mid` are 0. The rate register holds 0x11, so a bit lasts 744 prescaled ticks (372 card clocks).
- R2: `cclk_stb` pulses for one cycle every N master cycles, where N is `presc_val`. A value of 0 acts as 1.
- R3: `card_clk` changes level only in the cycle `cclk_stb` is high, so its period is 2N master cycles while `card_clk_on` is 1.
- R4: When `card_clk_on` is 0, a high phase of `card_clk` runs its full N cycles and then `card_clk` stays low. Toggling resumes once `card_clk_on` returns to 1.
- R5: The bit length in prescaled ticks is floor(2*Fi/Di). Fi is picked by `fd_val[7:4]`: codes 0,1→372, 2→558, 3→744, 4→1116, 5→1488, 6→1860, 9→512, 10→768, 11→1024, 12→1536, 13→2048. Di is picked by `fd_val[3:0]`: codes 1→1, 2→2, 3→4, 4→8, 5→16, 6→32, 7→64, 8→12, 9→20. `etu_edge` pulses once per bit, so consecutive pulses are that length times N master cycles apart.
- R6: `etu_mid` pulses floor(L/2)*N master cycles after each `etu_edge`, where L is the bit length in prescaled ticks.
- R7: A `fd_wr` pulse does not alter the bit in progress. The new length applies from the next `etu_edge` on.
- R8: If either nibble is a reserved code (Fi codes 7, 8, 14, 15; Di codes 0, 10 to 15), the bit length keeps its previous value.
- R9: `etu_edge` and `etu_mid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_val | input | 6 | Prescaler divide ratio |
| fd_val | input | 8 | Rate register value: Fi code in the high nibble, Di code in the low nibble |
| fd_wr | input | 1 | One-cycle write strobe for `fd_val` |
| card_clk_on | input | 1 | Card clock run enable; 0 parks the clock low |
| card_clk | output | 1 | Card clock |
| cclk_stb | output | 1 | Prescaled tick; marks each cycle in which `card_clk` may change |
| etu_edge | output | 1 | Bit boundary strobe |
| etu_mid | output | 1 | Bit centre sampling strobe |

## Verification
The hardest case to reach from the ports is a rate write that lands partway through a bit. It must be shown that the bit in flight keeps its old length while the next bit takes the new one. The stimulus synchronises to a boundary strobe and issues the write a fixed number of cycles into the bit. It then queues the old length for the current bit and the new length for the bits after it. Reserved codes are written the same way right after a length with an odd product, so a silently changed length would show up in the next interval.

// File: rtl/scg_pkg.sv
// Shared widths and rate-code decode functions for the card clock / bit timing
// generator. Assumes Fi codes up to 2048 and a bit length that fits 12 bits minus one.
package scg_pkg;
    localparam int PRE_W = 6;
    localparam int FD_W  = 8;
    localparam int ETU_W = 12;

    // Clock-rate conversion factor for a 4-bit code; 0 marks a reserved code.
    function automatic logic [11:0] fi_of(input logic [3:0] code);
        case (code)
            4'd0, 4'd1: fi_of = 12'd372;
            4'd2:       fi_of = 12'd558;
            4'd3:       fi_of = 12'd744;
            4'd4:       fi_of = 12'd1116;
            4'd5:       fi_of = 12'd1488;
            4'd6:       fi_of = 12'd1860;
            4'd9:       fi_of = 12'd512;
            4'd10:      fi_of = 12'd768;
            4'd11:      fi_of = 12'd1024;
            4'd12:      fi_of = 12'd1536;
            4'd13:      fi_of = 12'd2048;
            default:    fi_of = 12'd0;
        endcase
    endfunction

    // Baud-adjust divisor for a 4-bit code; 0 marks a reserved code.
    function automatic logic [6:0] di_of(input logic [3:0] code);
        case (code)
            4'd1:    di_of = 7'd1;
            4'd2:    di_of = 7'd2;
            4'd3:    di_of = 7'd4;
            4'd4:    di_of = 7'd8;
            4'd5:    di_of = 7'd16;
            4'd6:    di_of = 7'd32;
            4'd7:    di_of = 7'd64;
            4'd8:    di_of = 7'd12;
            4'd9:    di_of = 7'd20;
            default: di_of = 7'd0;
        endcase
    endfunction
endpackage

// File: rtl/scg_prescaler.sv
// Programmable prescaler. Produces a combinational tick every N master cycles
// (N = ratio, 0 treated as 1) and a registered copy of it. Assumes the ratio may
// change at any time; the count then wraps at the next reachable terminal value.
module scg_prescaler #(
    parameter int W = scg_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio,
    output logic         tick,
    output logic         tick_q
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    assign last = (ratio == '0) ? '0 : ratio - W'(1);
    assign tick = (cnt_q >= last);

    // Count master cycles and wrap on the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= tick ? '0 : cnt_q + W'(1);
    end

    // Register the tick as the externally visible strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick;
    end

    // R2
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio > W'(1) && $stable(ratio) && tick_q) |-> !tick);
endmodule

// File: rtl/scg_cardclk.sv
// Card clock toggle stage. Flips the clock on each prescaler tick while running;
// when stopped, the next tick drives it low and it stays there. Assumes tick is a
// single-cycle pulse from the prescaler, so a high phase is never cut short.
module scg_cardclk (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic cclk
);
    // Toggle when running, fall to low when stopped, only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cclk <= 1'b0;
        else if (tick) cclk <= run ? ~cclk : 1'b0;
    end

    // R3
    cclk_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cclk));

    // R4
    cclk_parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cclk) |=> !cclk);
endmodule

// File: rtl/scg_fd_decode.sv
// Rate-register decoder. Maps the Fi and Di codes to a bit length of floor(2*Fi/Di)
// prescaled ticks and returns it minus one as the counter limit. Flags reserved codes.
// Assumes the limit fits the counter width (largest length 4096).
module scg_fd_decode #(
    parameter int FD_W  = scg_pkg::FD_W,
    parameter int ETU_W = scg_pkg::ETU_W
) (
    input  logic [FD_W-1:0]  fd,
    output logic [ETU_W-1:0] lim,
    output logic             ok
);
    localparam int QW = ETU_W + 1;

    logic [11:0]   fi;
    logic [6:0]    di;
    logic [QW-1:0] quot;

    // Look up both factors and divide the doubled rate factor by the divisor.
    always_comb begin
        fi   = scg_pkg::fi_of(fd[FD_W-1 -: 4]);
        di   = scg_pkg::di_of(fd[3:0]);
        ok   = (fi != '0) && (di != '0);
        quot = ok ? (QW'({fi, 1'b0}) / QW'(di)) : QW'(1);
        lim  = ETU_W'(quot - QW'(1));
    end
endmodule

// File: rtl/scg_etu_div.sv
// Bit-time divider. Counts prescaled ticks up to a limit and emits a boundary
// strobe on wrap and a centre strobe when the count reaches half the length.
// Holds the rate register and applies a new decoded limit only at a boundary;
// reserved codes keep the old limit. Assumes tick is a single-cycle pulse.
module scg_etu_div #(
    parameter int FD_W    = scg_pkg::FD_W,
    parameter int ETU_W   = scg_pkg::ETU_W,
    parameter int FD_RST  = 8'h11,
    parameter int LIM_RST = 743
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [FD_W-1:0] fd_in,
    input  logic            fd_wr,
    output logic            edge_q,
    output logic            mid_q
);
    localparam int HW = ETU_W + 1;

    logic [FD_W-1:0]  fd_q;
    logic             pend_q;
    logic [ETU_W-1:0] cnt_q;
    logic [ETU_W-1:0] lim_q;
    logic [ETU_W-1:0] dec_lim;
    logic             dec_ok;
    logic             bound;
    logic             mid_hit;
    logic [HW-1:0]    half;

    scg_fd_decode #(.FD_W(FD_W), .ETU_W(ETU_W)) u_dec (
        .fd  (fd_q),
        .lim (dec_lim),
        .ok  (dec_ok)
    );

    assign bound   = tick && (cnt_q == lim_q);
    assign half    = (HW'(lim_q) + HW'(1)) >> 1;
    assign mid_hit = tick && ((HW'(cnt_q) + HW'(1)) == half);

    // Capture rate-register writes and mark them pending until a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fd_q   <= FD_W'(FD_RST);
            pend_q <= 1'b0;
        end else if (fd_wr) begin
            fd_q   <= fd_in;
            pend_q <= 1'b1;
        end else if (bound) begin
            pend_q <= 1'b0;
        end
    end

    // Take a new valid limit only at a bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lim_q <= ETU_W'(LIM_RST);
        else if (bound && pend_q && dec_ok)  lim_q <= dec_lim;
    end

    // Count prescaled ticks within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= bound ? '0 : cnt_q + ETU_W'(1);
    end

    // Register the boundary and centre strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
            mid_q  <= 1'b0;
        end else begin
            edge_q <= bound;
            mid_q  <= mid_hit;
        end
    end

    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);

    // R7
    lim_only_at_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bound |=> $stable(lim_q));

    // R9
    edge_mid_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(edge_q && mid_q));

    // R5
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q |=> !edge_q);
endmodule

// File: rtl/scg_clk_etu.sv
// Top of the card clock and bit-timing generator: prescaler, card clock toggle
// stage and bit-time divider driven from one master clock. Assumes all inputs are
// synchronous to clk.
module scg_clk_etu #(
    parameter int PRE_W = scg_pkg::PRE_W,
    parameter int FD_W  = scg_pkg::FD_W,
    parameter int ETU_W = scg_pkg::ETU_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc_val,
    input  logic [FD_W-1:0]  fd_val,
    input  logic             fd_wr,
    input  logic             card_clk_on,
    output logic             card_clk,
    output logic             cclk_stb,
    output logic             etu_edge,
    output logic             etu_mid
);
    logic tick;

    scg_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ratio  (presc_val),
        .tick   (tick),
        .tick_q (cclk_stb)
    );

    scg_cardclk u_cclk (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (card_clk_on),
        .cclk  (card_clk)
    );

    scg_etu_div #(.FD_W(FD_W), .ETU_W(ETU_W)) u_etu (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .fd_in  (fd_val),
        .fd_wr  (fd_wr),
        .edge_q (etu_edge),
        .mid_q  (etu_mid)
    );
endmodule

// File: tb/test_scg_clk_etu.sv
module test_scg_clk_etu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] presc_val = 6'd13;
    logic [7:0] fd_val = 8'h11;
    logic       fd_wr = 1'b0;
    logic       card_clk_on = 1'b1;
    logic       card_clk, cclk_stb, etu_edge, etu_mid;

    scg_clk_etu i_scg_clk_etu (
        .clk(clk), .rst_n(rst_n), .presc_val(presc_val), .fd_val(fd_val),
        .fd_wr(fd_wr), .card_clk_on(card_clk_on), .card_clk(card_clk),
        .cclk_stb(cclk_stb), .etu_edge(etu_edge), .etu_mid(etu_mid)
    );

    always #10 clk = ~clk;

    typedef struct { int per; int mid; string tag; } exp_t;
    exp_t exp_q[$];
    int   n_chk = 0, n_bad = 0;
    int   cyc = 0, last_edge = 0, mid_cyc = 0;
    bit   done = 0;
    event ev_edge;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Monitor: pops an expected bit interval at each boundary and compares it.
    always @(negedge clk) begin
        if (rst_n) begin
            if (etu_mid) mid_cyc = cyc;
            if (etu_edge) begin
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cyc - last_edge == e.per, {e.tag, " period"}, cyc - last_edge, e.per);
                    chk(mid_cyc - last_edge == e.mid, {e.tag, " centre R6"}, mid_cyc - last_edge, e.mid);
                    chk(!etu_mid, "R9 edge with centre", int'(etu_mid), 0);
                end
                last_edge = cyc;
                -> ev_edge;
            end
        end
    end

    // Driver: call right after a boundary event; queues n identical intervals.
    task automatic expect_run(input int per, input int mid, input int n, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{per, mid, tag});
        repeat (n) @ev_edge;
    endtask

    // Driver: write a rate code partway into the current bit (R7 ordering).
    task automatic fd_step(input logic [7:0] v, input int op, input int om,
                           input int np, input int nm, input string tag);
        exp_q.push_back('{op, om, "R7 bit in flight"});
        repeat (50) @(negedge clk);
        fd_val = v;
        fd_wr  = 1'b1;
        @(negedge clk);
        fd_wr  = 1'b0;
        exp_q.push_back('{np, nm, tag});
        exp_q.push_back('{np, nm, tag});
        repeat (3) @ev_edge;
    endtask

    task automatic stb_period(input int expv, input string tag);
        int n = 0;
        @(negedge clk iff cclk_stb);
        do begin @(negedge clk); n++; end while (!cclk_stb && n < 200);
        chk(n == expv, tag, n, expv);
    endtask

    task automatic cclk_period(input int expv, input string tag);
        int n = 0;
        @(negedge clk iff card_clk);
        @(negedge clk iff !card_clk);
        do begin @(negedge clk); n++; end while (!card_clk && n < 400);
        do begin @(negedge clk); n++; end while (card_clk && n < 400);
        chk(n == expv, tag, n, expv);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int hi;
        bit stayed;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state (first cycle out of reset)
        chk(card_clk == 0, "R1 card_clk", int'(card_clk), 0);
        chk(cclk_stb == 0, "R1 cclk_stb", int'(cclk_stb), 0);
        chk(etu_edge == 0, "R1 etu_edge", int'(etu_edge), 0);
        chk(etu_mid == 0, "R1 etu_mid", int'(etu_mid), 0);

        // R2 / R3 prescaler ratios
        stb_period(13, "R2 ratio 13");
        cclk_period(26, "R3 card clock ratio 13");
        presc_val = 6'd0;
        repeat (70) @(negedge clk);
        stb_period(1, "R2 ratio 0 acts as 1");
        presc_val = 6'd5;
        repeat (70) @(negedge clk);
        stb_period(5, "R2 ratio 5");
        cclk_period(10, "R3 card clock ratio 5");

        // R4 stop right after a rising edge: high phase completes, then held low
        @(negedge clk iff !card_clk);
        @(negedge clk iff card_clk);
        card_clk_on = 1'b0;
        hi = 0;
        while (card_clk && hi < 50) begin hi++; @(negedge clk); end
        chk(hi == 5, "R4 high phase kept", hi, 5);
        stayed = 1;
        repeat (60) begin @(negedge clk); if (card_clk) stayed = 0; end
        chk(stayed, "R4 parked low", int'(stayed), 1);
        card_clk_on = 1'b1;
        hi = 0;
        while (!card_clk && hi < 50) begin @(negedge clk); hi++; end
        chk(hi <= 10 && card_clk, "R4 restart", hi, 10);

        // Bit timing at ratio 2
        presc_val = 6'd2;
        repeat (2) @ev_edge;
        expect_run(1488, 744, 2, "R1 R5 default length");
        fd_step(8'h94, 1488, 744, 256, 128, "R5 R7 Fi512 Di8");
        fd_step(8'h18, 256, 128, 124, 62, "R5 Fi372 Di12");
        fd_step(8'h29, 124, 62, 110, 54, "R5 R6 Fi558 Di20 floor");
        fd_step(8'h71, 110, 54, 110, 54, "R8 reserved Fi");
        fd_step(8'h10, 110, 54, 110, 54, "R8 reserved Di zero");
        fd_step(8'hA1, 110, 54, 3072, 1536, "R5 Fi768 Di1");
        fd_step(8'hD1, 3072, 1536, 8192, 4096, "R5 Fi2048 longest");
        fd_step(8'h3F, 8192, 4096, 8192, 4096, "R8 reserved Di high");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule